// File: doc/BRIEF.md
# Microcoded Phase Sequencer

This block paces a microcoded processor through each instruction. It keeps the opcode byte of the instruction in flight and a phase counter. It also takes one live condition flag from the datapath. From these three values it forms the read address of an external microcode store. The store answers in the same cycle with a microword. The sequencer passes that microword to the datapath as the action word for the cycle. When the microword carries its end-of-instruction bit, the sequencer returns to an opcode fetch.

Two states drive the behaviour. In SQ_FETCH the byte on the memory path is captured as the new opcode, the phase is held at zero and no actions reach the datapath. The only exit is the load transition to SQ_EXEC. SQ_EXEC has three transitions:
- **step** stays in SQ_EXEC and advances the phase by one.
- **wrap** is taken when the last phase ends without the end bit. It stays in SQ_EXEC, returns the phase to zero and keeps the same opcode, so an instruction with no end bit repeats indefinitely, which is how a halt behaves.
- **end** is taken when the end bit is seen and goes back to SQ_FETCH.

A phase that does not depend on the flag is produced by writing the same word at both flag values of the store. The store contents, the datapath and the memory lie outside this block.

Top module: `phase_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it rises, `fetch` is 1, `exec_valid` is 0 and `phase` is 0, and the sequencer is in SQ_FETCH.
- R2: A cycle with `fetch` high loads `op_byte` into `opcode`. The next cycle is an SQ_EXEC cycle with `phase` 0.
- R3: `uaddr` equals {`opcode`, `phase`, `cond_flag`}, with the flag in bit 0, the phase in bits 4..1 and the opcode in bits 12..5. It follows `cond_flag` in the same cycle, with no register in between.
- R4: In an SQ_EXEC cycle whose microword has bit NEXT_BIT (bit 0 by default) clear and whose phase is below 15, the next cycle is SQ_EXEC with `phase` one higher and `opcode` unchanged.
- R5: In an SQ_EXEC cycle whose microword has bit NEXT_BIT set, the next cycle is SQ_FETCH with `phase` 0.
- R6: In an SQ_EXEC cycle at phase 15 whose microword has bit NEXT_BIT clear, the next cycle is SQ_EXEC with `phase` 0 and `opcode` unchanged. An opcode that never sets the bit, such as the halt opcode 0xFF, therefore cycles through all 16 phases repeatedly.
- R7: `act` equals `uword` in SQ_EXEC cycles and is all zeros in SQ_FETCH cycles. The microword, its NEXT_BIT included, has no effect on the sequence during SQ_FETCH.
- R8: Exactly one of `fetch` and `exec_valid` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_byte | input | 8 | Opcode byte read from program memory |
| cond_flag | input | 1 | Live condition flag from the datapath |
| uword | input | 16 | Microword returned by the store for `uaddr` |
| fetch | output | 1 | This cycle fetches an opcode (the program counter should advance) |
| exec_valid | output | 1 | This cycle executes a microword |
| phase | output | 4 | Current phase |
| opcode | output | 8 | Opcode currently executing |
| uaddr | output | 13 | Microcode store address |
| act | output | 16 | Microword forwarded to the datapath, zero during fetch |

## Verification
The wrap at phase 15 is hard to reach from the ports. It needs sixteen consecutive execute cycles with the end bit clear, while ordinary opcodes end early. The stimulus reaches it with a directed run of the halt opcode 0xFF, and with table opcodes whose end depends on the flag and which only finish when the random flag is 1. A bench-side override raises the end bit at random times, including during fetch cycles, to show that the bit is ignored there.

// File: rtl/phase_seq_pkg.sv
package phase_seq_pkg;

    typedef enum logic {
        SQ_FETCH = 1'b0,
        SQ_EXEC  = 1'b1
    } seq_state_t;

endpackage

// File: rtl/phase_seq_ctrl.sv
module phase_seq_ctrl
    import phase_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic end_req,
    output logic fetch,
    output logic exec_valid,
    output logic op_load,
    output logic ph_clear,
    output logic ph_step
);

    seq_state_t state_q;
    seq_state_t state_d;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_FETCH: state_d = SQ_EXEC;                       // load
            SQ_EXEC:  state_d = end_req ? SQ_FETCH : SQ_EXEC;  // end / step / wrap
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_FETCH;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        fetch      = 1'b0;
        exec_valid = 1'b0;
        op_load    = 1'b0;
        ph_clear   = 1'b0;
        ph_step    = 1'b0;
        unique case (state_q)
            SQ_FETCH: begin
                fetch    = 1'b1;
                op_load  = 1'b1;
                ph_clear = 1'b1;
            end
            SQ_EXEC: begin
                exec_valid = 1'b1;
                ph_clear   = end_req;
                ph_step    = !end_req;
            end
        endcase
    end

endmodule

// File: rtl/phase_seq_ctr.sv
module phase_seq_ctr #(
    parameter int PH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            step,
    output logic [PH_W-1:0] phase
);

    // modular increment: the last phase rolls back to zero (wrap)
    always_ff @(posedge clk) begin
        if (!rst_n || clear) phase <= '0;
        else if (step)       phase <= phase + PH_W'(1);
    end

endmodule

// File: rtl/phase_seq_opreg.sv
module phase_seq_opreg #(
    parameter int OP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [OP_W-1:0] din,
    output logic [OP_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= din;
    end

endmodule

// File: rtl/phase_seq.sv
module phase_seq #(
    parameter int OP_W     = 8,
    parameter int PH_W     = 4,
    parameter int UWORD_W  = 16,
    parameter int NEXT_BIT = 0,
    localparam int ADDR_W  = OP_W + PH_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OP_W-1:0]    op_byte,
    input  logic               cond_flag,
    input  logic [UWORD_W-1:0] uword,
    output logic               fetch,
    output logic               exec_valid,
    output logic [PH_W-1:0]    phase,
    output logic [OP_W-1:0]    opcode,
    output logic [ADDR_W-1:0]  uaddr,
    output logic [UWORD_W-1:0] act
);

    logic op_load;
    logic ph_clear;
    logic ph_step;

    phase_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .end_req    (uword[NEXT_BIT]),
        .fetch      (fetch),
        .exec_valid (exec_valid),
        .op_load    (op_load),
        .ph_clear   (ph_clear),
        .ph_step    (ph_step)
    );

    phase_seq_ctr #(.PH_W(PH_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ph_clear),
        .step  (ph_step),
        .phase (phase)
    );

    phase_seq_opreg #(.OP_W(OP_W)) u_opreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (op_load),
        .din   (op_byte),
        .q     (opcode)
    );

    // store address: opcode, then phase, flag in the lowest bit
    assign uaddr = {opcode, phase, cond_flag};

    // actions reach the datapath only while executing
    assign act = exec_valid ? uword : '0;

endmodule

// File: rtl/phase_seq_chk.sv
module phase_seq_chk #(
    parameter int OP_W     = 8,
    parameter int PH_W     = 4,
    parameter int UWORD_W  = 16,
    parameter int NEXT_BIT = 0
) (
    input logic               clk,
    input logic               rst_n,
    input logic [OP_W-1:0]    op_byte,
    input logic [UWORD_W-1:0] uword,
    input logic               fetch,
    input logic               exec_valid,
    input logic [PH_W-1:0]    phase,
    input logic [OP_W-1:0]    opcode
);

    localparam logic [PH_W-1:0] PH_LAST = {PH_W{1'b1}};

    // R2
    load_enters_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |=> (exec_valid && phase == '0 && opcode == $past(op_byte)));

    // R4
    step_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && !uword[NEXT_BIT] && phase != PH_LAST)
        |=> (exec_valid && phase == $past(phase) + PH_W'(1) && $stable(opcode)));

    // R5
    end_returns_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && uword[NEXT_BIT]) |=> (fetch && phase == '0));

    // R6
    wrap_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && !uword[NEXT_BIT] && phase == PH_LAST)
        |=> (exec_valid && phase == '0 && $stable(opcode)));

    // R8
    one_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch != exec_valid);

endmodule

bind phase_seq phase_seq_chk #(
    .OP_W(OP_W), .PH_W(PH_W), .UWORD_W(UWORD_W), .NEXT_BIT(NEXT_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_byte    (op_byte),
    .uword      (uword),
    .fetch      (fetch),
    .exec_valid (exec_valid),
    .phase      (phase),
    .opcode     (opcode)
);

// File: tb/phase_seq_bench.sv
module phase_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  op_byte = 8'h00;
    logic        cond_flag = 1'b0;
    logic [15:0] uword;
    logic        fetch, exec_valid;
    logic [3:0]  phase;
    logic [7:0]  opcode;
    logic [12:0] uaddr;
    logic [15:0] act;
    logic        force_end = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    // behavioural store: end-of-instruction bit per opcode, phase, flag
    function automatic logic tbl_end(input logic [7:0] op, input logic [3:0] ph, input logic fl);
        if (op == 8'hEA) return ph == 4'd0;
        if (op == 8'hFF) return 1'b0;
        if (op[7])       return (ph >= op[3:0]) && fl;
        return ph == {1'b0, op[2:0]};
    endfunction

    function automatic logic [15:0] tbl_word(input logic [12:0] a, input logic e);
        return {a ^ 13'h0A5A, 2'b10, e};
    endfunction

    assign uword = tbl_word(uaddr, tbl_end(uaddr[12:5], uaddr[4:1], uaddr[0]) | force_end);

    phase_seq u_phase_seq (
        .clk(clk), .rst_n(rst_n), .op_byte(op_byte), .cond_flag(cond_flag),
        .uword(uword), .fetch(fetch), .exec_valid(exec_valid), .phase(phase),
        .opcode(opcode), .uaddr(uaddr), .act(act)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // model of the expected state
    logic       m_fetch = 1'b1;
    logic [3:0] m_ph = 4'd0;
    logic [7:0] m_op = 8'h00;
    string      m_tag = "R1";

    task automatic cycle(input logic [7:0] ob, input logic fl, input logic fe);
        logic e;
        logic [12:0] ea;
        op_byte = ob; cond_flag = fl; force_end = fe;
        #1;
        ea = {m_op, m_ph, fl};
        chk({m_tag, " fetch"}, 32'(fetch), 32'(m_fetch));
        chk({m_tag, " phase"}, 32'(phase), 32'(m_ph));
        chk({m_tag, " opcode"}, 32'(opcode), 32'(m_op));
        chk("R3 uaddr", 32'(uaddr), 32'(ea));
        chk("R8 exclusive", 32'(fetch ^ exec_valid), 32'd1);
        e = tbl_end(m_op, m_ph, fl) | fe;
        chk("R7 act", 32'(act), m_fetch ? 32'd0 : 32'(tbl_word(ea, e)));
        if (m_fetch) begin
            m_op = ob; m_ph = 4'd0; m_fetch = 1'b0;
            m_tag = fe ? "R7" : "R2";
        end else if (e) begin
            m_ph = 4'd0; m_fetch = 1'b1; m_tag = "R5";
        end else if (m_ph == 4'd15) begin
            m_ph = 4'd0; m_tag = "R6";
        end else begin
            m_ph = m_ph + 4'd1; m_tag = "R4";
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = 32'h1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1: reset state
        #1;
        chk("R1 fetch in reset", 32'(fetch), 32'd1);
        chk("R1 exec in reset", 32'(exec_valid), 32'd0);
        chk("R1 phase in reset", 32'(phase), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // directed: no-operation opcode ends after one phase
        cycle(8'hEA, 1'b0, 1'b0);
        cycle(8'h00, 1'b1, 1'b0);
        // directed: halt opcode wraps twice, flag toggling
        cycle(8'hFF, 1'b0, 1'b0);
        for (int i = 0; i < 34; i++) cycle(8'h00, 1'(i), 1'b0);
        // R5 forced end from halt
        cycle(8'h00, 1'b0, 1'b1);
        // R7: end bit raised during fetch is ignored
        cycle(8'h8F, 1'b0, 1'b1);
        for (int i = 0; i < 20; i++) cycle(8'h00, 1'b0, 1'b0);
        // random mix
        for (int i = 0; i < 1500; i++)
            cycle(8'($urandom), 1'($urandom), ($urandom % 16) == 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule